// File: doc/BRIEF.md
# Capability Access Permission Checker

This block decides whether a memory access made through a capability may proceed. A capability arrives with bounds that are already decompressed. It carries a validity tag, a sealed flag, three permission bits, a 64-bit base, a 64-bit top and a 64-bit cursor address. An access kind and an access size come with it. The block returns an allow bit. On a denial it also returns a cause code that names one reason.

The checks are independent tests on tag validity, sealing, the permission bit for the access kind, and full-range bounds. When several tests fail at once, a fixed priority picks the reported cause. A parameter selects between a purely combinational result and a result held in one register stage.

Top module: `capAccessChecker`

## Requirements
- R1: When the tag is clear on a valid request, the response denies the access with cause 1.
- R2: When the tag is set and the capability is sealed, the response denies the access with cause 2.
- R3: The permission bits are `capPerms[0]` for load, `capPerms[1]` for store and `capPerms[2]` for fetch. The kind codes are 0 for load, 1 for store and 2 for fetch. A missing bit for the requested kind gives cause 3. Kind code 3 is reserved and always gives cause 3.
- R4: An access is in bounds only when base ≤ addr and addr + size ≤ top. An access that ends exactly at top is allowed. Otherwise the cause is 4.
- R5: The end address addr + size is formed at 65 bits, so an access that wraps past the top of the 64-bit space gives cause 4 even when top is all ones.
- R6: When several faults apply, the reported cause follows the order tag (1), then seal (2), then permission (3), then length (4).
- R7: The size code `accSizeLog` gives 2^code bytes, so codes 0 to 4 select 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 give cause 4.
- R8: `rspAllow` is 1 exactly when the response is valid and its cause is 0. A cycle with no valid response shows allow 0 and cause 0.
- R9: With `REGISTERED` = 1 (the default), the response for a request appears one clock after it, and `rspValid` follows `reqValid` by one clock.
- R10: While `rstN` is low, `rspValid`, `rspAllow` and `rspCause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A check is requested this cycle |
| capTag | input | 1 | Capability validity tag |
| capSealed | input | 1 | Capability is sealed |
| capPerms | input | 3 | Permission bits: fetch, store, load (MSB to LSB) |
| capBase | input | 64 | Lower bound, inclusive |
| capTop | input | 64 | Upper bound, exclusive |
| capAddr | input | 64 | Cursor address of the access |
| accKind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| accSizeLog | input | 3 | log2 of the access size in bytes |
| rspValid | output | 1 | Response is valid |
| rspAllow | output | 1 | Access is permitted |
| rspCause | output | 3 | 0 none, 1 tag, 2 seal, 3 permission, 4 length |

## Verification
The permission test and the bounds test can fail on the same request. For example, a store without its permission bit can also run past top. The tag and seal faults can also stack on top of either. Directed vectors stack these faults in every nesting. Random vectors with sparse permissions and addresses placed near the bounds make overlaps frequent. Each response is compared every clock against a behavioural model in the bench that applies the priority order. A mismatch in cause shows which fault won.

// File: rtl/capchk_pkg.sv
package capchk_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_TAG    = 3'd1,
    CAUSE_SEAL   = 3'd2,
    CAUSE_PERM   = 3'd3,
    CAUSE_LENGTH = 3'd4
  } cause_e;

  // Raw outcome of each independent test, before priority selection.
  typedef struct packed {
    logic tagBad;
    logic sealBad;
    logic permBad;
    logic lenBad;
  } faultVec_t;

  // Strobes from control to the datapath result stage.
  typedef struct packed {
    logic capture;
    logic clearResult;
  } stageStrobe_t;

endpackage

// File: rtl/capBoundsUnit.sv
module capBoundsUnit #(
  parameter int ADDR_W       = 64,
  parameter int SIZE_CODE_W  = 3,
  parameter int MAX_SIZE_LOG = 4
) (
  input  logic [ADDR_W-1:0]      base,
  input  logic [ADDR_W-1:0]      top,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [SIZE_CODE_W-1:0] sizeCode,
  output logic                   inBounds
);

  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] accBytes;
  logic [EXT_W-1:0] endAddr;
  logic             sizeOk;
  logic             lowOk;
  logic             highOk;

  // Size codes beyond the largest supported access never pass.
  assign sizeOk   = (sizeCode <= SIZE_CODE_W'(MAX_SIZE_LOG));
  assign accBytes = {{ADDR_W{1'b0}}, 1'b1} << sizeCode;

  // The extra bit keeps a carry out of the address space visible.
  assign endAddr  = {1'b0, addr} + accBytes;
  assign lowOk    = (addr >= base);
  assign highOk   = (endAddr <= {1'b0, top});
  assign inBounds = sizeOk & lowOk & highOk;

endmodule

// File: rtl/capChkDatapath.sv
module capChkDatapath
  import capchk_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter int PERM_W       = 3,
  parameter int KIND_W       = 2,
  parameter int SIZE_CODE_W  = 3,
  parameter int MAX_SIZE_LOG = 4,
  parameter bit REGISTERED   = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   capTag,
  input  logic                   capSealed,
  input  logic [PERM_W-1:0]      capPerms,
  input  logic [ADDR_W-1:0]      capBase,
  input  logic [ADDR_W-1:0]      capTop,
  input  logic [ADDR_W-1:0]      capAddr,
  input  logic [KIND_W-1:0]      accKind,
  input  logic [SIZE_CODE_W-1:0] accSizeLog,
  input  stageStrobe_t           strobe,
  input  cause_e                 selCause,
  output faultVec_t              faults,
  output logic                   rspAllow,
  output logic [2:0]             rspCause
);

  logic [PERM_W-1:0] permHit;
  logic              inBounds;
  logic              nextAllow;
  logic [2:0]        nextCause;

  // One match term per permission bit; a kind with no bit matches nothing.
  for (genvar k = 0; k < PERM_W; k++) begin : g_perm
    assign permHit[k] = (accKind == KIND_W'(k)) & capPerms[k];
  end

  capBoundsUnit #(
    .ADDR_W      (ADDR_W),
    .SIZE_CODE_W (SIZE_CODE_W),
    .MAX_SIZE_LOG(MAX_SIZE_LOG)
  ) bounds_i (
    .base    (capBase),
    .top     (capTop),
    .addr    (capAddr),
    .sizeCode(accSizeLog),
    .inBounds(inBounds)
  );

  assign faults.tagBad  = ~capTag;
  assign faults.sealBad = capSealed;
  assign faults.permBad = ~|permHit;
  assign faults.lenBad  = ~inBounds;

  assign nextAllow = strobe.capture && (selCause == CAUSE_NONE);
  assign nextCause = strobe.capture ? selCause : CAUSE_NONE;

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rspAllow <= 1'b0;
        rspCause <= CAUSE_NONE;
      end else if (strobe.capture || strobe.clearResult) begin
        rspAllow <= nextAllow;
        rspCause <= nextCause;
      end
    end
  end else begin : g_comb
    assign rspAllow = nextAllow & rstN;
    assign rspCause = rstN ? nextCause : CAUSE_NONE;
  end

endmodule

// File: rtl/capChkControl.sv
module capChkControl
  import capchk_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  faultVec_t    faults,
  output stageStrobe_t strobe,
  output cause_e       selCause,
  output logic         rspValid
);

  // Fixed priority: tag, seal, permission, length.
  always_comb begin
    if (faults.tagBad)       selCause = CAUSE_TAG;
    else if (faults.sealBad) selCause = CAUSE_SEAL;
    else if (faults.permBad) selCause = CAUSE_PERM;
    else if (faults.lenBad)  selCause = CAUSE_LENGTH;
    else                     selCause = CAUSE_NONE;
  end

  assign strobe.capture     = reqValid;
  assign strobe.clearResult = ~reqValid;

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rspValid <= 1'b0;
      else       rspValid <= reqValid;
    end
  end else begin : g_comb
    assign rspValid = reqValid & rstN;
  end

endmodule

// File: rtl/capAccessChecker.sv
module capAccessChecker
  import capchk_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter int PERM_W       = 3,
  parameter int KIND_W       = 2,
  parameter int SIZE_CODE_W  = 3,
  parameter int MAX_SIZE_LOG = 4,
  parameter bit REGISTERED   = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   capTag,
  input  logic                   capSealed,
  input  logic [PERM_W-1:0]      capPerms,
  input  logic [ADDR_W-1:0]      capBase,
  input  logic [ADDR_W-1:0]      capTop,
  input  logic [ADDR_W-1:0]      capAddr,
  input  logic [KIND_W-1:0]      accKind,
  input  logic [SIZE_CODE_W-1:0] accSizeLog,
  output logic                   rspValid,
  output logic                   rspAllow,
  output logic [2:0]             rspCause
);

  faultVec_t    faults;
  stageStrobe_t strobe;
  cause_e       selCause;

  capChkDatapath #(
    .ADDR_W      (ADDR_W),
    .PERM_W      (PERM_W),
    .KIND_W      (KIND_W),
    .SIZE_CODE_W (SIZE_CODE_W),
    .MAX_SIZE_LOG(MAX_SIZE_LOG),
    .REGISTERED  (REGISTERED)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .capTag    (capTag),
    .capSealed (capSealed),
    .capPerms  (capPerms),
    .capBase   (capBase),
    .capTop    (capTop),
    .capAddr   (capAddr),
    .accKind   (accKind),
    .accSizeLog(accSizeLog),
    .strobe    (strobe),
    .selCause  (selCause),
    .faults    (faults),
    .rspAllow  (rspAllow),
    .rspCause  (rspCause)
  );

  capChkControl #(
    .REGISTERED(REGISTERED)
  ) ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .faults  (faults),
    .strobe  (strobe),
    .selCause(selCause),
    .rspValid(rspValid)
  );

endmodule

// File: rtl/capChkChecker.sv
module capChkChecker #(
  parameter int SIZE_CODE_W = 3,
  parameter bit REGISTERED  = 1'b1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic                   capTag,
  input logic                   capSealed,
  input logic [2:0]             capPerms,
  input logic [1:0]             accKind,
  input logic [SIZE_CODE_W-1:0] accSizeLog,
  input logic                   rspValid,
  input logic                   rspAllow,
  input logic [2:0]             rspCause
);

  logic pastOk;
  logic reqTagBad;
  logic reqSealBad;
  logic reqPermBad;
  logic reqSizeBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  assign reqTagBad  = reqValid && !capTag;
  assign reqSealBad = reqValid && capTag && capSealed;
  assign reqPermBad = reqValid && capTag && !capSealed &&
                      ((accKind == 2'd3) ||
                       (accKind == 2'd0 && !capPerms[0]) ||
                       (accKind == 2'd1 && !capPerms[1]) ||
                       (accKind == 2'd2 && !capPerms[2]));
  assign reqSizeBad = reqValid && capTag && !capSealed && !reqPermBad &&
                      (accSizeLog > SIZE_CODE_W'(4));

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r10: assert (!rspValid && !rspAllow && rspCause == 3'd0);
    end
  end

  p_allow_means_clean_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspAllow |-> (rspValid && rspCause == 3'd0));

  p_cause_in_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspCause <= 3'd4);

  if (REGISTERED) begin : g_reg
    p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rstN)
      pastOk |-> (rspValid == $past(reqValid)));

    p_tag_fault_r1: assert property (@(posedge clk) disable iff (!rstN)
      (pastOk && $past(reqTagBad)) |-> (rspCause == 3'd1 && !rspAllow));

    p_seal_fault_r2: assert property (@(posedge clk) disable iff (!rstN)
      (pastOk && $past(reqSealBad)) |-> (rspCause == 3'd2));

    p_perm_fault_r3: assert property (@(posedge clk) disable iff (!rstN)
      (pastOk && $past(reqPermBad)) |-> (rspCause == 3'd3));

    p_size_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
      (pastOk && $past(reqSizeBad)) |-> (rspCause == 3'd4));
  end else begin : g_comb
    p_tag_fault_r1: assert property (@(posedge clk) disable iff (!rstN)
      reqTagBad |-> (rspCause == 3'd1 && !rspAllow));

    p_seal_fault_r2: assert property (@(posedge clk) disable iff (!rstN)
      reqSealBad |-> (rspCause == 3'd2));

    p_perm_fault_r3: assert property (@(posedge clk) disable iff (!rstN)
      reqPermBad |-> (rspCause == 3'd3));

    p_size_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
      reqSizeBad |-> (rspCause == 3'd4));
  end

endmodule

bind capAccessChecker capChkChecker #(
  .SIZE_CODE_W(SIZE_CODE_W),
  .REGISTERED (REGISTERED)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .capTag    (capTag),
  .capSealed (capSealed),
  .capPerms  (capPerms),
  .accKind   (accKind),
  .accSizeLog(accSizeLog),
  .rspValid  (rspValid),
  .rspAllow  (rspAllow),
  .rspCause  (rspCause)
);

// File: tb/capAccessChecker_tb_top.sv
module capAccessChecker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam longint unsigned ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        capTag = 1'b0;
  logic        capSealed = 1'b0;
  logic [2:0]  capPerms = 3'd0;
  logic [63:0] capBase = 64'd0;
  logic [63:0] capTop = 64'd0;
  logic [63:0] capAddr = 64'd0;
  logic [1:0]  accKind = 2'd0;
  logic [2:0]  accSizeLog = 3'd0;
  logic        rspValid;
  logic        rspAllow;
  logic [2:0]  rspCause;

  int    nVec = 0;
  int    nFail = 0;
  bit    done = 1'b0;
  int    expValidQ[$];
  int    expCauseQ[$];
  string expTagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  capAccessChecker dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .capTag(capTag),
    .capSealed(capSealed), .capPerms(capPerms), .capBase(capBase),
    .capTop(capTop), .capAddr(capAddr), .accKind(accKind),
    .accSizeLog(accSizeLog), .rspValid(rspValid), .rspAllow(rspAllow),
    .rspCause(rspCause)
  );

  // Behavioural model of the requirements.
  function automatic int modelCause(bit tg, bit sl, logic [2:0] pm, int kind,
                                    longint unsigned b, longint unsigned t,
                                    longint unsigned a, int sz);
    logic [64:0] lastByteEnd;
    if (!tg) return 1;
    if (sl) return 2;
    if (kind == 3 || !pm[kind]) return 3;
    if (sz > 4) return 4;
    if (a < b) return 4;
    lastByteEnd = {1'b0, a} + (65'd1 << sz);
    if (lastByteEnd > {1'b0, t}) return 4;
    return 0;
  endfunction

  task automatic compareOne();
    int ev, ec;
    string tg;
    ev = expValidQ.pop_front();
    ec = expCauseQ.pop_front();
    tg = expTagQ.pop_front();
    nVec++;
    if (rspValid !== ev[0]) begin
      nFail++;
      $display("FAIL R9 %s: rspValid=%0b expected %0b", tg, rspValid, ev[0]);
    end
    if (rspCause !== 3'(ec)) begin
      nFail++;
      $display("FAIL %s: rspCause=%0d expected %0d", tg, rspCause, ec);
    end
    if (rspAllow !== (ev[0] && ec == 0)) begin
      nFail++;
      $display("FAIL R8 %s: rspAllow=%0b expected %0b", tg, rspAllow,
               (ev[0] && ec == 0));
    end
  endtask

  // Called at a falling edge: check the response of the previous request, then drive.
  task automatic step(bit v, bit tg, bit sl, logic [2:0] pm, int kind,
                      longint unsigned b, longint unsigned t,
                      longint unsigned a, int sz, string rq);
    @(negedge clk);
    compareOne();
    reqValid   = v;
    capTag     = tg;
    capSealed  = sl;
    capPerms   = pm;
    accKind    = 2'(kind);
    capBase    = b;
    capTop     = t;
    capAddr    = a;
    accSizeLog = 3'(sz);
    expValidQ.push_back(int'(v));
    expCauseQ.push_back(v ? modelCause(tg, sl, pm, kind, b, t, a, sz) : 0);
    expTagQ.push_back(rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R9 watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    // R10: outputs quiet during reset.
    repeat (3) begin
      @(negedge clk);
      nVec++;
      if (rspValid !== 1'b0 || rspAllow !== 1'b0 || rspCause !== 3'd0) begin
        nFail++;
        $display("FAIL R10: got v=%0b a=%0b c=%0d expected 0 0 0",
                 rspValid, rspAllow, rspCause);
      end
    end
    rstN = 1'b1;
    expValidQ.push_back(0); expCauseQ.push_back(0); expTagQ.push_back("R10 idle");

    // R8: clean load within bounds.
    step(1, 1, 0, 3'b111, 0, 64'h1000, 64'h1010, 64'h1000, 2, "R8 clean load");
    // R1: tag clear.
    step(1, 0, 0, 3'b111, 0, 64'h1000, 64'h1010, 64'h1000, 0, "R1 tag clear");
    // R2: sealed.
    step(1, 1, 1, 3'b111, 1, 64'h1000, 64'h1010, 64'h1000, 0, "R2 sealed");
    // R3: each kind missing its bit, and the reserved kind.
    step(1, 1, 0, 3'b110, 0, 64'h1000, 64'h1010, 64'h1000, 0, "R3 no load");
    step(1, 1, 0, 3'b101, 1, 64'h1000, 64'h1010, 64'h1000, 0, "R3 no store");
    step(1, 1, 0, 3'b011, 2, 64'h1000, 64'h1010, 64'h1000, 0, "R3 no fetch");
    step(1, 1, 0, 3'b111, 3, 64'h1000, 64'h1010, 64'h1000, 0, "R3 reserved kind");
    step(1, 1, 0, 3'b100, 2, 64'h1000, 64'h1010, 64'h1004, 2, "R3 fetch ok");
    // R4: bounds edges.
    step(1, 1, 0, 3'b111, 1, 64'h1000, 64'h1010, 64'h1008, 3, "R4 ends at top");
    step(1, 1, 0, 3'b111, 1, 64'h1000, 64'h1010, 64'h1009, 3, "R4 one past top");
    step(1, 1, 0, 3'b111, 0, 64'h1000, 64'h1010, 64'h0FFF, 0, "R4 below base");
    step(1, 1, 0, 3'b111, 0, 64'h1000, 64'h1000, 64'h1000, 0, "R4 empty region");
    step(1, 1, 0, 3'b111, 0, 64'h1000, 64'h1010, 64'h1000, 4, "R4 full 16 bytes");
    // R5: wrap-around at the top of the address space.
    step(1, 1, 0, 3'b111, 0, 64'd0, ALL1, ALL1 - 7, 4, "R5 wrap 16");
    step(1, 1, 0, 3'b111, 0, 64'd0, ALL1, ALL1 - 7, 3, "R5 end at 2^64");
    step(1, 1, 0, 3'b111, 0, 64'd0, ALL1, ALL1 - 15, 3, "R5 just fits");
    // R7: reserved size codes.
    step(1, 1, 0, 3'b111, 0, 64'h0, 64'h1000, 64'h0, 5, "R7 size code 5");
    step(1, 1, 0, 3'b111, 1, 64'h0, 64'h1000, 64'h0, 6, "R7 size code 6");
    step(1, 1, 0, 3'b111, 2, 64'h0, 64'h1000, 64'h0, 7, "R7 size code 7");
    // R6: stacked faults.
    step(1, 0, 1, 3'b000, 1, 64'h1000, 64'h1010, 64'h2000, 4, "R6 tag wins");
    step(1, 1, 1, 3'b000, 1, 64'h1000, 64'h1010, 64'h2000, 4, "R6 seal wins");
    step(1, 1, 0, 3'b000, 1, 64'h1000, 64'h1010, 64'h2000, 4, "R6 perm wins");
    step(1, 1, 0, 3'b010, 1, 64'h1000, 64'h1010, 64'h2000, 7, "R6 length only");
    // R8/R9: idle cycles carrying faulty data, and alternation.
    step(0, 0, 1, 3'b000, 3, 64'h0, 64'h0, 64'h5, 7, "R8 idle faulty data");
    step(1, 1, 0, 3'b111, 0, 64'h0, 64'h100, 64'h10, 0, "R9 after idle");
    step(0, 1, 0, 3'b111, 0, 64'h0, 64'h100, 64'h10, 0, "R9 idle again");
    step(1, 0, 0, 3'b111, 0, 64'h0, 64'h100, 64'h10, 0, "R9 fault after idle");

    // Random cases with overlapping faults.
    for (int i = 0; i < 3000; i++) begin
      longint unsigned b, t, a, span;
      bit v, tg, sl;
      logic [2:0] pm;
      int kind, sz;
      v    = ($urandom_range(0, 9) != 0);
      tg   = ($urandom_range(0, 9) != 0);
      sl   = ($urandom_range(0, 9) == 0);
      pm   = ($urandom_range(0, 2) == 0) ? 3'(($urandom)) : 3'b111;
      kind = $urandom_range(0, 3);
      sz   = ($urandom_range(0, 15) == 0) ? $urandom_range(5, 7) : $urandom_range(0, 4);
      span = longint'($urandom_range(0, 64));
      if ($urandom_range(0, 7) == 0) b = ALL1 - longint'($urandom_range(0, 40));
      else b = {$urandom, $urandom};
      t = b + span;
      if (t < b) t = ALL1;
      a = b + longint'($urandom_range(0, 80)) - 8;
      step(v, tg, sl, pm, kind, b, t, a, sz, "R6 random");
    end

    @(negedge clk);
    compareOne();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule